// File: doc/BRIEF.md
# JTAG Debug Access Bridge to Wishbone Memory

This block is a JTAG test access port whose data registers are windows onto system memory. An external debugger drives TCK, TMS, TDI and an optional asynchronous test reset. It selects one of a few instructions and shifts words in and out. The bridge turns each memory shift into a single Wishbone classic cycle on the system-clock side. This works while the rest of the chip runs normally, and TCK may be far slower than the system clock.

Three memory instructions exist. The address instruction exposes a word-address register: Capture-DR copies the current address into the shift path, and Update-DR loads the shifted-in word as the new address. The read instruction issues a memory read on entry to Capture-DR, so the fetched word is in the shift path before the first bit leaves. Update-DR then advances the address by one. The read-write instruction does the same read, and on Update-DR it also writes the shifted-in word to that address before the address advances. An identification instruction returns a fixed code. Every other code selects a one-bit bypass register.

Requests travel from the TCK domain to the system domain as a toggle carried through a two-flop synchroniser, together with an address, a write flag and write data that are held stable. Read data returns in a system-domain register. The TCK side samples that register one TCK period after it issued the read.

Top module: `jtag_wb_bridge`

## Requirements
- R1: The TAP controller follows the standard sixteen-state JTAG state machine. It reaches Test-Logic-Reset after five consecutive TCK rising edges with TMS high, and at once when trstN is low.
- R2: Reaching Test-Logic-Reset by either route selects the identification instruction and clears the word-address register to zero.
- R3: The instruction register is 4 bits wide and shifts LSB first. Capture-IR loads 4'b0001, so the bits shifted out during an instruction load are 1, 0, 0, 0.
- R4: Instruction 4'b0001 selects a 32-bit identification register that shifts out 32'h000018FF LSB first. It gives the same value on every read, including while the system reset rst is high.
- R5: Instruction 4'b0101 selects the 30-bit word-address register. A DR scan shifts out the address currently held, LSB first, and Update-DR loads the shifted-in 30 bits as the new address.
- R6: Instruction 4'b0110 selects the 32-bit data register for reading. Each DR scan shifts out, LSB first, the word stored at the current address. Update-DR increments the address by one and writes nothing to memory.
- R7: Instruction 4'b0111 selects the data register for read-write. Each DR scan shifts out the word held at the current address before the scan. Update-DR writes the shifted-in word to that address and then increments the address by one.
- R8: Any instruction code other than the four above selects a 1-bit bypass register that captures 0. Its output is TDI delayed by one shift.
- R9: Each memory access is one Wishbone classic cycle. wbCyc and wbStb rise and fall together, and wbSel is all ones while wbCyc is high. wbAdr, wbWe and wbDatO hold steady until wbAck. wbCyc falls on the clock after wbAck, and wbWe is high only inside a cycle.
- R10: All memory instructions work while rst is low and the system runs, when the TCK period is at least eight system clock periods. Requests cross from TCK to clk through a toggle and a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | JTAG test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| wbCyc | output | 1 | Wishbone cycle |
| wbStb | output | 1 | Wishbone strobe |
| wbWe | output | 1 | Wishbone write enable |
| wbSel | output | DATA_W/8 | Wishbone byte selects |
| wbAdr | output | ADDR_W | Wishbone word address |
| wbDatO | output | DATA_W | Write data to memory |
| wbDatI | input | DATA_W | Read data from memory |
| wbAck | input | 1 | Wishbone acknowledge |

## Verification
The bench goes after the address auto-increment. After two read-write scans starting at word 1, reloading the address must shift out 3. A bridge that increments on capture or forgets to increment would give 1 or 5 there, and its later reads would land on the wrong words. Read-write scans must return the old contents while storing the new ones, and a later read-only scan carrying all-ones data must leave memory unchanged; a bridge that wrote under the read instruction would return FFFFFFFF afterwards. A TMS-driven reset must both restore the identification instruction and zero a nonzero address. The bypass path must show its captured zero followed by TDI delayed by one bit; an off-by-one shift would misalign every bit.

// File: rtl/jtag_wb_pkg.sv
package jtag_wb_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] INS_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] INS_ADDR   = 4'b0101;
  localparam logic [IR_W-1:0] INS_READ   = 4'b0110;
  localparam logic [IR_W-1:0] INS_RW     = 4'b0111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  // Strobes from the TAP control to the datapath, all in the TCK domain.
  typedef struct packed {
    logic inReset;     // state is Test-Logic-Reset
    logic capDr;       // state is Capture-DR
    logic shDr;        // state is Shift-DR
    logic shIr;        // state is Shift-IR
    logic enterCapDr;  // next state is Capture-DR
    logic enterUpdDr;  // next state is Update-DR
    logic selId;
    logic selAddr;
    logic selRead;
    logic selRw;
  } dr_ctl_t;

endpackage

// File: rtl/jtag_wb_tap_ctrl.sv
module jtag_wb_tap_ctrl
  import jtag_wb_pkg::*;
(
  input  logic    tck,
  input  logic    trstN,
  input  logic    tms,
  input  logic    tdi,
  output dr_ctl_t ctl,
  output logic    irTdo
);

  tap_state_t state, nextState;
  logic [IR_W-1:0] irShift, irHold;

  always_comb begin
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      default:   nextState = tms ? ST_SEL_DR : ST_IDLE;  // ST_UPD_IR
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irHold  <= INS_IDCODE;
    end else begin
      unique case (state)
        ST_RESET:  irHold  <= INS_IDCODE;
        ST_CAP_IR: irShift <= IR_CAPTURE;
        ST_SH_IR:  irShift <= {tdi, irShift[IR_W-1:1]};
        ST_UPD_IR: irHold  <= irShift;
        default:   ;
      endcase
    end
  end

  assign irTdo          = irShift[0];
  assign ctl.inReset    = (state == ST_RESET);
  assign ctl.capDr      = (state == ST_CAP_DR);
  assign ctl.shDr       = (state == ST_SH_DR);
  assign ctl.shIr       = (state == ST_SH_IR);
  assign ctl.enterCapDr = (nextState == ST_CAP_DR);
  assign ctl.enterUpdDr = (nextState == ST_UPD_DR);
  assign ctl.selId      = (irHold == INS_IDCODE);
  assign ctl.selAddr    = (irHold == INS_ADDR);
  assign ctl.selRead    = (irHold == INS_READ);
  assign ctl.selRw      = (irHold == INS_RW);

endmodule

// File: rtl/jtag_wb_datapath.sv
module jtag_wb_datapath
  import jtag_wb_pkg::*;
#(
  parameter int          ADDR_W   = 30,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h000018FF
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  dr_ctl_t           ctl,
  input  logic              irTdo,
  input  logic [DATA_W-1:0] rdData,
  output logic              tdo,
  output logic              reqTgl,
  output logic              reqWe,
  output logic [ADDR_W-1:0] reqAdr,
  output logic [DATA_W-1:0] reqDat
);

  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);
  localparam logic [DATA_W-1:0] ID_WORD   = DATA_W'(ID_VALUE);

  logic [ADDR_W-1:0] addrReg, addrShift;
  logic [DATA_W-1:0] dataShift;
  logic              bypassBit;
  logic              memSel;

  assign memSel = ctl.selRead | ctl.selRw;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      addrReg   <= '0;
      addrShift <= '0;
      dataShift <= '0;
      bypassBit <= 1'b0;
      reqTgl    <= 1'b0;
      reqWe     <= 1'b0;
      reqAdr    <= '0;
      reqDat    <= '0;
    end else begin
      if (ctl.inReset) addrReg <= '0;
      if (ctl.capDr) begin
        bypassBit <= 1'b0;
        if (ctl.selAddr) addrShift <= addrReg;
        if (ctl.selId)   dataShift <= ID_WORD;
        if (memSel)      dataShift <= rdData;
      end
      if (ctl.shDr) begin
        addrShift <= {tdi, addrShift[ADDR_W-1:1]};
        dataShift <= {tdi, dataShift[DATA_W-1:1]};
        bypassBit <= tdi;
      end
      // Read issued as Capture-DR is entered; its result is sampled on leaving it.
      if (ctl.enterCapDr && memSel) begin
        reqTgl <= ~reqTgl;
        reqWe  <= 1'b0;
        reqAdr <= addrReg;
      end
      // Write and address step as Update-DR is entered.
      if (ctl.enterUpdDr) begin
        if (ctl.selAddr) addrReg <= addrShift;
        if (memSel)      addrReg <= addrReg + ADDR_STEP;
        if (ctl.selRw) begin
          reqTgl <= ~reqTgl;
          reqWe  <= 1'b1;
          reqAdr <= addrReg;
          reqDat <= dataShift;
        end
      end
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                     tdo <= 1'b0;
    else if (ctl.shIr)              tdo <= irTdo;
    else if (ctl.selAddr)           tdo <= addrShift[0];
    else if (ctl.selId || memSel)   tdo <= dataShift[0];
    else                            tdo <= bypassBit;
  end

endmodule

// File: rtl/jtag_wb_sys_master.sv
module jtag_wb_sys_master #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqTgl,
  input  logic              reqWe,
  input  logic [ADDR_W-1:0] reqAdr,
  input  logic [DATA_W-1:0] reqDat,
  output logic [DATA_W-1:0] rdData,
  output logic              wbCyc,
  output logic              wbWe,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  input  logic              wbAck
);

  logic [1:0] syncQ;
  logic       seenTgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ   <= '0;
      seenTgl <= 1'b0;
      wbCyc   <= 1'b0;
      wbWe    <= 1'b0;
      wbAdr   <= '0;
      wbDatO  <= '0;
      rdData  <= '0;
    end else begin
      syncQ <= {syncQ[0], reqTgl};
      if (!wbCyc) begin
        // A toggle is only taken up once the previous cycle has finished.
        if (syncQ[1] != seenTgl) begin
          seenTgl <= syncQ[1];
          wbCyc   <= 1'b1;
          wbWe    <= reqWe;
          wbAdr   <= reqAdr;
          wbDatO  <= reqDat;
        end
      end else if (wbAck) begin
        wbCyc <= 1'b0;
        wbWe  <= 1'b0;
        if (!wbWe) rdData <= wbDatI;
      end
    end
  end

endmodule

// File: rtl/jtag_wb_bridge.sv
module jtag_wb_bridge
  import jtag_wb_pkg::*;
#(
  parameter int          ADDR_W   = 30,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h000018FF,
  localparam int         SEL_W    = DATA_W / 8
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic              clk,
  input  logic              rst,
  output logic              wbCyc,
  output logic              wbStb,
  output logic              wbWe,
  output logic [SEL_W-1:0]  wbSel,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  input  logic              wbAck
);

  dr_ctl_t           ctl;
  logic              irTdo;
  logic              reqTgl, reqWe;
  logic [ADDR_W-1:0] reqAdr;
  logic [DATA_W-1:0] reqDat, rdData;

  jtag_wb_tap_ctrl ctrl_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .ctl(ctl), .irTdo(irTdo)
  );

  jtag_wb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) dp_i (
    .tck(tck), .trstN(trstN), .tdi(tdi), .ctl(ctl), .irTdo(irTdo), .rdData(rdData),
    .tdo(tdo), .reqTgl(reqTgl), .reqWe(reqWe), .reqAdr(reqAdr), .reqDat(reqDat)
  );

  jtag_wb_sys_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) sys_i (
    .clk(clk), .rst(rst), .reqTgl(reqTgl), .reqWe(reqWe), .reqAdr(reqAdr),
    .reqDat(reqDat), .rdData(rdData), .wbCyc(wbCyc), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatO(wbDatO), .wbDatI(wbDatI), .wbAck(wbAck)
  );

  assign wbStb = wbCyc;
  assign wbSel = {SEL_W{1'b1}};

endmodule

// File: rtl/jtag_wb_bridge_chk.sv
module jtag_wb_bridge_chk #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wbCyc,
  input logic              wbStb,
  input logic              wbWe,
  input logic [SEL_W-1:0]  wbSel,
  input logic [ADDR_W-1:0] wbAdr,
  input logic [DATA_W-1:0] wbDatO,
  input logic              wbAck
);

  // R9: an open cycle stays open until acknowledged
  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && !wbAck) |=> wbCyc);

  // R9: address, direction and write data frozen while waiting for ack
  p_stable_payload_r9: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && !wbAck) |=> ($stable(wbAdr) && $stable(wbWe) && $stable(wbDatO)));

  // R9: single classic cycle ends right after ack
  p_drop_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbAck) |=> !wbCyc);

  // R9: strobe and full byte select travel with cycle
  p_strobe_sel_r9: assert property (@(posedge clk) disable iff (rst)
    wbCyc |-> (wbStb && (wbSel == {SEL_W{1'b1}})));

  // R9: write enable only inside a cycle
  p_we_in_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    wbWe |-> wbCyc);

endmodule

bind jtag_wb_bridge jtag_wb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
  .wbSel(wbSel), .wbAdr(wbAdr), .wbDatO(wbDatO), .wbAck(wbAck)
);

// File: tb/jtag_wb_bridge_tb_top.sv
module jtag_wb_bridge_tb_top;

  localparam int CLK_HALF = 2.5;
  localparam int TCK_HALF = 40;
  localparam int NV = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo;
  logic wbCyc, wbStb, wbWe, wbAck;
  logic [3:0]  wbSel;
  logic [29:0] wbAdr;
  logic [31:0] wbDatO, wbDatI;
  logic [31:0] mem [16];

  int checks = 0, failures = 0, selErrs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #(TCK_HALF) tck = ~tck;

  jtag_wb_bridge dut_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbSel(wbSel), .wbAdr(wbAdr), .wbDatO(wbDatO), .wbDatI(wbDatI), .wbAck(wbAck)
  );

  // Memory model: one wait state, ack for one cycle.
  assign wbDatI = mem[wbAdr[3:0]];
  always @(posedge clk) begin
    if (rst) begin
      wbAck <= 1'b0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'hC0DE0000 | i;
    end else begin
      wbAck <= wbCyc && wbStb && !wbAck;
      if (wbCyc && wbStb && !wbAck && wbWe) mem[wbAdr[3:0]] <= wbDatO;
    end
  end

  // R9 monitor: strobe and selects while a cycle is open
  always @(negedge clk) if (!rst && wbCyc && (!wbStb || wbSel != 4'hF)) selErrs++;

  // ir, data in, expected data out. Runs with the system out of reset (R10).
  localparam logic [67:0] VEC [NV] = '{
    {4'b0001, 32'h00000000, 32'h000018FF},  // R4
    {4'b0101, 32'h00000001, 32'h00000000},  // R5
    {4'b0111, 32'h55555555, 32'hC0DE0001},  // R7
    {4'b0111, 32'hAAAAAAAA, 32'hC0DE0002},  // R7
    {4'b0101, 32'h00000001, 32'h00000003},  // R5 after two increments
    {4'b0111, 32'hAAAAAAAA, 32'h55555555},  // R7
    {4'b0111, 32'h55555555, 32'hAAAAAAAA},  // R7
    {4'b0101, 32'h00000001, 32'h00000003},  // R5
    {4'b0110, 32'hFFFFFFFF, 32'hAAAAAAAA},  // R6
    {4'b0110, 32'h00000000, 32'h55555555},  // R6
    {4'b0101, 32'h00000001, 32'h00000003},  // R5
    {4'b0110, 32'h00000000, 32'hAAAAAAAA},  // R6 nothing written
    {4'b0110, 32'h00000000, 32'h55555555},  // R6
    {4'b0101, 32'h00000000, 32'h00000003},  // R5 back to word 0
    {4'b0110, 32'h00000000, 32'hC0DE0000}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tapStep(input logic tmsV, input logic tdiV, output logic tdoV);
    @(negedge tck);
    #2;
    tms = tmsV;
    tdi = tdiV;
    #(TCK_HALF - 12);
    tdoV = tdo;
    @(posedge tck);
  endtask

  task automatic shiftIr(input logic [3:0] code, output logic [3:0] capOut);
    logic b;
    tapStep(1'b1, 1'b0, b);
    tapStep(1'b1, 1'b0, b);
    tapStep(1'b0, 1'b0, b);
    tapStep(1'b0, 1'b0, b);
    for (int i = 0; i < 4; i++) begin
      tapStep(i == 3, code[i], b);
      capOut[i] = b;
    end
    tapStep(1'b1, 1'b0, b);
    tapStep(1'b0, 1'b0, b);
  endtask

  task automatic shiftDr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic b;
    dout = '0;
    tapStep(1'b1, 1'b0, b);
    tapStep(1'b0, 1'b0, b);
    tapStep(1'b0, 1'b0, b);
    for (int i = 0; i < n; i++) begin
      tapStep(i == n - 1, din[i], b);
      dout[i] = b;
    end
    tapStep(1'b1, 1'b0, b);
    tapStep(1'b0, 1'b0, b);
  endtask

  function automatic string tagOf(input logic [3:0] ir);
    case (ir)
      4'b0101: return "R5 address scan";
      4'b0110: return "R6 read scan";
      4'b0111: return "R7 read-write scan";
      default: return "R4 idcode scan";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] dout, dout2;
    logic [3:0]  cap;
    logic        b;
    // Both resets applied; JTAG used while rst stays high.
    #100;
    trstN = 1'b1;
    @(negedge clk);
    check("R9 reset wbCyc", {31'b0, wbCyc}, 32'h0);
    tapStep(1'b0, 1'b0, b);  // Test-Logic-Reset -> Run-Test/Idle
    shiftDr(32, 32'h0, dout);
    check("R4 idcode in system reset", dout, 32'h000018FF);
    shiftDr(32, 32'hFFFFFFFF, dout2);
    check("R4 idcode repeat in system reset", dout2, dout);
    @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    shiftIr(4'b0001, cap);
    check("R3 capture-ir pattern", {28'b0, cap}, 32'h1);

    for (int v = 0; v < NV; v++) begin
      logic [3:0]  ir;
      logic [31:0] din, exp;
      int          n;
      {ir, din, exp} = VEC[v];
      n = (ir == 4'b0101) ? 30 : 32;
      shiftIr(ir, cap);
      shiftDr(n, din, dout);
      if (n == 30) exp = exp & 32'h3FFFFFFF;
      check(tagOf(ir), dout, exp);
    end

    // R8: unknown code gives one-bit bypass, captured 0 then delayed TDI
    shiftIr(4'b1111, cap);
    shiftDr(8, 32'h000000B2, dout);
    check("R8 bypass", dout, 32'h00000064);

    // R1 and R2: TMS reset from a nonzero address
    shiftIr(4'b0101, cap);
    shiftDr(30, 32'h00000007, dout);
    for (int k = 0; k < 5; k++) tapStep(1'b1, 1'b0, b);
    tapStep(1'b0, 1'b0, b);
    shiftDr(32, 32'h0, dout);
    check("R1 R2 tms reset selects idcode", dout, 32'h000018FF);
    shiftIr(4'b0101, cap);
    shiftDr(30, 32'h0, dout);
    check("R2 tms reset clears address", dout, 32'h0);

    check("R9 stb and sel during cycles", selErrs, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule